// File: doc/BRIEF.md
# CAN Error Status and Interrupt Flags

This block keeps the error and status word of a CAN controller and turns its three sticky event flags into one interrupt request. The protocol engine feeds it the live fault confinement state, the type of the last transmit bit error, one-cycle pulses for receive and transmit errors, a low-power stop indication and the synchronized bus level. Three mask enables arrive as plain inputs. The block presents a 16-bit status word on a register read port and accepts writes that clear flags.

`rd_data` always shows the current word. A cycle with `rd_en` high counts as a read. A flag becomes clearable only after a read has returned it as one. A later write of zero to that bit then clears it, and writing one to it does nothing. The interrupt line is registered. It is the OR over the three flags, each ANDed with its mask.

Word layout, with bit 0 as the least significant bit: [0] error flag, [1] bus-off flag, [2] wake flag, [4:3] confinement state, [6:5] transmit bit error, [7] receive error seen in the previous cycle, [8] transmit error seen in the previous cycle. Bits [15:9] read zero.

Top module: `can_errstat_irq`

## Requirements
- R1: While reset is active and directly after it, the whole status word reads 0 and `irq` is 0.
- R2: Bits [4:3] show the confinement state sampled at the previous clock edge: 00 error active, 01 error passive, 10 or 11 bus off.
- R3: Bits [6:5] show the previous cycle's transmit bit error: 00 none, 01 a dominant bit read back recessive, 10 a recessive bit read back dominant. Input code 11 is reported as 00, so 11 never appears.
- R4: Error flag bit [0] sets after an edge that samples `rx_err_pulse`, `tx_err_pulse` or a transmit bit error code of 01 or 10. Bits [7] and [8] show the receive and transmit error pulses one cycle late. Code 11 alone does not set the flag.
- R5: Bus-off flag bit [1] sets only when the confinement state enters bus off, meaning its high bit goes from 0 to 1. Staying in bus off does not set it again.
- R6: Wake flag bit [2] sets only when `stop_mode` is high and `bus_lvl` goes from 1 (recessive) to 0 (dominant) between two sampled cycles.
- R7: A flag clears only on a write of 0 to its bit after an earlier read cycle returned it as 1. A zero write with no prior read, a read and write in the same cycle, and a write of 1 all leave the flag set.
- R8: When a set event and a valid clear meet in one cycle, the flag stays 1. The set event also cancels the earlier read, so a following zero write does not clear the flag.
- R9: `irq` equals the OR of (flag AND mask) over the three flags, one clock after those values.
- R10: With a flag's mask low, that flag never raises `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fcs_in | input | 2 | Fault confinement state from the protocol engine |
| txbit_err_in | input | 2 | Transmit bit error type |
| rx_err_pulse | input | 1 | One-cycle receive error event |
| tx_err_pulse | input | 1 | One-cycle transmit error event |
| stop_mode | input | 1 | Low-power stop mode active |
| bus_lvl | input | 1 | Synchronized bus level, 1 = recessive |
| wake_en | input | 1 | Wake interrupt mask |
| boff_en | input | 1 | Bus-off interrupt mask |
| err_en | input | 1 | Error interrupt mask |
| rd_en | input | 1 | Read strobe, arms flags that read as 1 |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data; a 0 bit requests a clear |
| rd_data | output | 16 | Status word |
| irq | output | 1 | Combined registered interrupt request |

## Verification
Each event, field value, read and write is sampled at one clock edge and shows in `rd_data` right after that edge. The interrupt line shows it one edge later. The bench drives inputs on the falling edge and checks the status word after the next rising edge. It checks `irq` once after the edge that sets a flag, where it must still be low, and again after the following edge. Clearing is tested as separate cycles: read, then write. Cases that must not change a flag are checked in the cycle right after the stimulus.

// File: rtl/can_estat_pkg.sv
package can_estat_pkg;
  localparam int WORD_W   = 16;
  localparam int NFLAG    = 3;
  localparam int B_ERR    = 0;
  localparam int B_BOFF   = 1;
  localparam int B_WAKE   = 2;
  localparam int B_FCS_LO = 3;
  localparam int B_TXB_LO = 5;
  localparam int B_RXE    = 7;
  localparam int B_TXE    = 8;

  typedef enum logic [1:0] {
    TXB_NONE = 2'b00,
    TXB_DOM_REC = 2'b01,
    TXB_REC_DOM = 2'b10,
    TXB_BAD = 2'b11
  } txb_e;
endpackage

// File: rtl/can_estat_events.sv
module can_estat_events (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] fcs_in,
  input  logic [1:0] txbit_err_in,
  input  logic       rx_err_pulse,
  input  logic       tx_err_pulse,
  input  logic       stop_mode,
  input  logic       bus_lvl,
  output logic [1:0] fcs_q,
  output logic [1:0] txb_q,
  output logic       rxe_q,
  output logic       txe_q,
  output logic       err_set,
  output logic       boff_set,
  output logic       wake_set
);
  import can_estat_pkg::*;

  logic       bus_q;
  logic       txb_valid;
  logic [1:0] txb_clean;

  // Code 11 is unused: fold it to "no error".
  assign txb_valid = (txbit_err_in == TXB_DOM_REC) || (txbit_err_in == TXB_REC_DOM);
  assign txb_clean = txb_valid ? txbit_err_in : TXB_NONE;

  assign err_set  = rx_err_pulse | tx_err_pulse | txb_valid;
  assign boff_set = fcs_in[1] & ~fcs_q[1];
  assign wake_set = stop_mode & bus_q & ~bus_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcs_q <= 2'b00;
      txb_q <= 2'b00;
      rxe_q <= 1'b0;
      txe_q <= 1'b0;
      bus_q <= 1'b1;
    end else begin
      fcs_q <= fcs_in;
      txb_q <= txb_clean;
      rxe_q <= rx_err_pulse;
      txe_q <= tx_err_pulse;
      bus_q <= bus_lvl;
    end
  end
endmodule

// File: rtl/can_estat_flag.sv
module can_estat_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic rd_ev,
  input  logic clr_req,
  output logic flag_q
);
  logic arm_q;
  logic clr_ok;

  assign clr_ok = clr_req & arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (set_ev)      flag_q <= 1'b1;
      else if (clr_ok) flag_q <= 1'b0;

      if (set_ev || clr_ok)    arm_q <= 1'b0;
      else if (rd_ev && flag_q) arm_q <= 1'b1;
    end
  end
endmodule

// File: rtl/can_estat_irq.sv
module can_estat_irq #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flags,
  input  logic [N-1:0] masks,
  output logic         irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(flags & masks);
  end
endmodule

// File: rtl/can_errstat_irq.sv
module can_errstat_irq
  import can_estat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        fcs_in,
  input  logic [1:0]        txbit_err_in,
  input  logic              rx_err_pulse,
  input  logic              tx_err_pulse,
  input  logic              stop_mode,
  input  logic              bus_lvl,
  input  logic              wake_en,
  input  logic              boff_en,
  input  logic              err_en,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  output logic              irq
);
  logic [1:0]       fcs_q, txb_q;
  logic             rxe_q, txe_q;
  logic [NFLAG-1:0] set_vec, flag_vec, mask_vec;

  can_estat_events u_ev (
    .clk(clk), .rst_n(rst_n),
    .fcs_in(fcs_in), .txbit_err_in(txbit_err_in),
    .rx_err_pulse(rx_err_pulse), .tx_err_pulse(tx_err_pulse),
    .stop_mode(stop_mode), .bus_lvl(bus_lvl),
    .fcs_q(fcs_q), .txb_q(txb_q), .rxe_q(rxe_q), .txe_q(txe_q),
    .err_set(set_vec[B_ERR]), .boff_set(set_vec[B_BOFF]),
    .wake_set(set_vec[B_WAKE])
  );

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    can_estat_flag u_flag (
      .clk(clk), .rst_n(rst_n),
      .set_ev(set_vec[i]),
      .rd_ev(rd_en),
      .clr_req(wr_en & ~wr_data[i]),
      .flag_q(flag_vec[i])
    );
  end

  assign mask_vec[B_ERR]  = err_en;
  assign mask_vec[B_BOFF] = boff_en;
  assign mask_vec[B_WAKE] = wake_en;

  can_estat_irq #(.N(NFLAG)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .flags(flag_vec), .masks(mask_vec), .irq(irq)
  );

  always_comb begin
    rd_data = '0;
    rd_data[NFLAG-1:0]          = flag_vec;
    rd_data[B_FCS_LO+1:B_FCS_LO] = fcs_q;
    rd_data[B_TXB_LO+1:B_TXB_LO] = txb_q;
    rd_data[B_RXE]              = rxe_q;
    rd_data[B_TXE]              = txe_q;
  end
endmodule

// File: rtl/can_estat_chk.sv
module can_estat_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  fcs_in,
  input logic        stop_mode,
  input logic        wake_en,
  input logic        boff_en,
  input logic        err_en,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic [15:0] rd_data,
  input logic        irq
);
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_zero: assert (rd_data == 16'h0 && !irq);
    end
  end

  a_r3_no_unused_code: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[6:5] != 2'b11);

  a_r5_boff_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (fcs_in[1] && !rd_data[4]) |=> rd_data[1]);

  a_r6_wake_needs_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[2]) |-> $past(stop_mode));

  for (genvar i = 0; i < 3; i++) begin : g_w1
    a_r7_write_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[i] && wr_en && wr_data[i]) |=> rd_data[i]);
  end

  a_r9_irq_latency: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq == $past(|(rd_data[2:0] & {wake_en, boff_en, err_en})));
endmodule

bind can_errstat_irq can_estat_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fcs_in(fcs_in), .stop_mode(stop_mode),
  .wake_en(wake_en), .boff_en(boff_en), .err_en(err_en),
  .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
);

// File: tb/can_errstat_irq_tb_top.sv
module can_errstat_irq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  fcs_in, txbit_err_in;
  logic        rx_err_pulse, tx_err_pulse, stop_mode, bus_lvl;
  logic        wake_en, boff_en, err_en, rd_en, wr_en;
  logic [15:0] wr_data, rd_data;
  logic        irq;
  int          checks = 0;
  int          errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_errstat_irq dut_i (
    .clk(clk), .rst_n(rst_n), .fcs_in(fcs_in), .txbit_err_in(txbit_err_in),
    .rx_err_pulse(rx_err_pulse), .tx_err_pulse(tx_err_pulse),
    .stop_mode(stop_mode), .bus_lvl(bus_lvl), .wake_en(wake_en),
    .boff_en(boff_en), .err_en(err_en), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    rx_err_pulse = 0; tx_err_pulse = 0; txbit_err_in = 2'b00;
    rd_en = 0; wr_en = 0; wr_data = 16'hFFFF;
  endtask

  task automatic do_reset();
    idle();
    fcs_in = 2'b00; stop_mode = 0; bus_lvl = 1;
    wake_en = 0; boff_en = 0; err_en = 0;
    rst_n = 0;
    step(); step();
    rst_n = 1;
    step();
  endtask

  task automatic read_then_clear(int bitn);
    rd_en = 1; step(); rd_en = 0;
    wr_en = 1; wr_data = ~(16'h1 << bitn); step(); idle();
  endtask

  task automatic t_reset();
    idle(); fcs_in = 2'b11; stop_mode = 0; bus_lvl = 1;
    wake_en = 1; boff_en = 1; err_en = 1;
    rst_n = 0; step();
    chk("R1 word in reset", rd_data, 0);
    chk("R1 irq in reset", irq, 0);
    do_reset();
    chk("R1 word after reset", rd_data, 0);
    chk("R1 irq after reset", irq, 0);
  endtask

  task automatic t_fcs();
    do_reset();
    fcs_in = 2'b01; step();
    chk("R2 passive field", rd_data[4:3], 2'b01);
    chk("R5 no boff for passive", rd_data[1], 0);
    fcs_in = 2'b10; step();
    chk("R2 busoff field 10", rd_data[4:3], 2'b10);
    chk("R5 boff on entry", rd_data[1], 1);
    step(); step();
    chk("R10 boff masked no irq", irq, 0);
    read_then_clear(1);
    chk("R7 boff cleared", rd_data[1], 0);
    fcs_in = 2'b11; step();
    chk("R2 busoff field 11", rd_data[4:3], 2'b11);
    chk("R5 staying busoff no refire", rd_data[1], 0);
    fcs_in = 2'b00; step();
    chk("R2 active field", rd_data[4:3], 2'b00);
    fcs_in = 2'b11; step();
    chk("R5 re-entry sets", rd_data[1], 1);
  endtask

  task automatic t_txbit();
    do_reset();
    txbit_err_in = 2'b11; step(); idle();
    chk("R3 code 11 reported 00", rd_data[6:5], 2'b00);
    chk("R4 code 11 no error flag", rd_data[0], 0);
    txbit_err_in = 2'b01; step(); idle();
    chk("R3 dom-rec code", rd_data[6:5], 2'b01);
    chk("R4 txbit sets error flag", rd_data[0], 1);
    txbit_err_in = 2'b10; step(); idle();
    chk("R3 rec-dom code", rd_data[6:5], 2'b10);
    step();
    chk("R3 field follows input", rd_data[6:5], 2'b00);
  endtask

  task automatic t_err();
    do_reset();
    rx_err_pulse = 1; step(); idle();
    chk("R4 rx bit", rd_data[8:7], 2'b01);
    chk("R4 rx sets flag", rd_data[0], 1);
    step();
    chk("R4 rx bit falls", rd_data[7], 0);
    do_reset();
    tx_err_pulse = 1; step(); idle();
    chk("R4 tx bit", rd_data[8:7], 2'b10);
    chk("R4 tx sets flag", rd_data[0], 1);
  endtask

  task automatic t_wake();
    do_reset();
    bus_lvl = 0; step();
    chk("R6 no wake outside stop", rd_data[2], 0);
    stop_mode = 1; step();
    chk("R6 steady dominant no wake", rd_data[2], 0);
    bus_lvl = 1; step();
    chk("R6 rising edge no wake", rd_data[2], 0);
    bus_lvl = 0; step();
    chk("R6 wake on falling edge in stop", rd_data[2], 1);
  endtask

  task automatic t_clear();
    do_reset();
    rx_err_pulse = 1; step(); idle();
    wr_en = 1; wr_data = 16'hFFFE; step(); idle();
    chk("R7 zero write without read", rd_data[0], 1);
    rd_en = 1; wr_en = 1; wr_data = 16'hFFFE; step(); idle();
    chk("R7 read and write same cycle", rd_data[0], 1);
    wr_en = 1; wr_data = 16'hFFFF; step(); idle();
    chk("R7 write one no effect", rd_data[0], 1);
    wr_en = 1; wr_data = 16'hFFFE; step(); idle();
    chk("R7 armed zero write clears", rd_data[0], 0);
  endtask

  task automatic t_setwins();
    do_reset();
    rx_err_pulse = 1; step(); idle();
    rd_en = 1; step(); idle();
    wr_en = 1; wr_data = 16'hFFFE; tx_err_pulse = 1; step(); idle();
    chk("R8 set beats clear", rd_data[0], 1);
    wr_en = 1; wr_data = 16'hFFFE; step(); idle();
    chk("R8 set disarms", rd_data[0], 1);
  endtask

  task automatic t_irq();
    do_reset();
    err_en = 1;
    rx_err_pulse = 1; step(); idle();
    chk("R9 flag set", rd_data[0], 1);
    chk("R9 irq not yet", irq, 0);
    step();
    chk("R9 irq one cycle later", irq, 1);
    err_en = 0; step();
    chk("R10 mask off drops irq", irq, 0);
    err_en = 1; step();
    read_then_clear(0);
    chk("R9 irq lags clear", irq, 1);
    step();
    chk("R9 irq drops after clear", irq, 0);
  endtask

  initial begin
    int cnt = 0;
    while (cnt < WATCHDOG) begin
      @(posedge clk);
      cnt++;
    end
    errors++;
    $display("FAIL watchdog actual=%0d expected=<%0d", cnt, WATCHDOG);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0;
    idle();
    fcs_in = 0; stop_mode = 0; bus_lvl = 1;
    wake_en = 0; boff_en = 0; err_en = 0;
    @(negedge clk);
    t_reset();
    t_fcs();
    t_txbit();
    t_err();
    t_wake();
    t_clear();
    t_setwins();
    t_irq();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule